// File: doc/BRIEF.md
# Two-Port General-Purpose I/O Register Block

This block is the register file behind two general-purpose I/O ports: a wide port of eight pins and a narrow port of four pins. A processor reaches it through a plain register bus with a single address, a write strobe and write data on one cycle, and combinational read data. For each port it keeps the output data, the per-pin direction and a synchronized copy of the pin levels. The wide port also has a per-pin input-disable mask.

Each pin's pad receives three signals: the output value, an output enable and a weak-pullup enable. A pin set as an output drives its output-data bit. A pin set as an input uses that same bit to turn its weak pullup on. Pin levels pass through a two-flop synchronizer before software can read them. A wide-port pin whose input buffer is disabled reads as 0.

Top module: `gpio_pair_regs`

## Requirements
- R1: After reset, the register at 00h reads FFh, 01h reads 0Fh, and the direction registers (02h for port 0, 03h for port 1) and the port 0 input-disable register (0Ah) read 00h. Every pin starts as an input with its pullup on.
- R2: The port 0 output register at 00h holds all 8 written bits and reads them back.
- R3: The port 1 output register at 01h stores only written bits 3:0. Bits 7:4 always read 0.
- R4: A pin whose direction bit is 1 asserts its output enable, drives its output-register bit and has its pullup off.
- R5: A pin whose direction bit is 0 has its output enable off and its pullup enable equal to its output-register bit.
- R6: Writing either direction register leaves both output registers unchanged.
- R7: Pin levels appear at 08h (port 0) and 09h (port 1, bits 3:0) after exactly two rising clock edges. Bits 7:4 of 09h read 0.
- R8: A port 0 bit whose input-disable bit at 0Ah is 1 reads as 0 at 08h. The other bits still show their pins.
- R9: Writes to 08h, 09h or an unmapped address change no register. Reads from unmapped addresses return 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 4 | Register address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr, combinational |
| p0PinIn | input | 8 | Port 0 pad levels, asynchronous |
| p0PinOut | output | 8 | Port 0 output values |
| p0OutEn | output | 8 | Port 0 output enables |
| p0PullUp | output | 8 | Port 0 weak-pullup enables |
| p1PinIn | input | 4 | Port 1 pad levels, asynchronous |
| p1PinOut | output | 4 | Port 1 output values |
| p1OutEn | output | 4 | Port 1 output enables |
| p1PullUp | output | 4 | Port 1 weak-pullup enables |

## Verification
The bench builds the block with its default parameters: an 8-bit port 0, a 4-bit port 1, an 8-bit data path and two synchronizer stages. The 4-bit port 1 makes the read-as-zero upper bits and the discarded upper write bits observable. The two-stage depth lets the bench pin down the exact edge on which a pin change becomes readable. With 8 pins on port 0, mixed direction and input-disable masks can be applied, and each bit's pad signals and read value can be checked against the mask.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;

  // Register offsets; the output and input offsets are fixed by software.
  localparam int OFS_OUT0   = 'h0;
  localparam int OFS_OUT1   = 'h1;
  localparam int OFS_DIR0   = 'h2;
  localparam int OFS_DIR1   = 'h3;
  localparam int OFS_IN0    = 'h8;
  localparam int OFS_IN1    = 'h9;
  localparam int OFS_INDIS0 = 'hA;

  typedef struct packed {
    logic wrOut0;
    logic wrOut1;
    logic wrDir0;
    logic wrDir1;
    logic wrInDis0;
  } gpioStrobe_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_OUT0,
    SEL_OUT1,
    SEL_DIR0,
    SEL_DIR1,
    SEL_IN0,
    SEL_IN1,
    SEL_INDIS0
  } gpioRdSel_t;

endpackage

// File: rtl/gpio_pair_ctrl.sv
module gpio_pair_ctrl
  import gpio_pair_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output gpioStrobe_t       stb,
  output gpioRdSel_t        rdSel
);

  logic hitOut0, hitOut1, hitDir0, hitDir1, hitIn0, hitIn1, hitInDis0;

  always_comb begin
    hitOut0   = (busAddr == ADDR_W'(OFS_OUT0));
    hitOut1   = (busAddr == ADDR_W'(OFS_OUT1));
    hitDir0   = (busAddr == ADDR_W'(OFS_DIR0));
    hitDir1   = (busAddr == ADDR_W'(OFS_DIR1));
    hitIn0    = (busAddr == ADDR_W'(OFS_IN0));
    hitIn1    = (busAddr == ADDR_W'(OFS_IN1));
    hitInDis0 = (busAddr == ADDR_W'(OFS_INDIS0));
  end

  always_comb begin
    stb.wrOut0   = busWrEn & hitOut0;
    stb.wrOut1   = busWrEn & hitOut1;
    stb.wrDir0   = busWrEn & hitDir0;
    stb.wrDir1   = busWrEn & hitDir1;
    stb.wrInDis0 = busWrEn & hitInDis0;
  end

  always_comb begin
    rdSel = SEL_NONE;
    if (hitOut0)        rdSel = SEL_OUT0;
    else if (hitOut1)   rdSel = SEL_OUT1;
    else if (hitDir0)   rdSel = SEL_DIR0;
    else if (hitDir1)   rdSel = SEL_DIR1;
    else if (hitIn0)    rdSel = SEL_IN0;
    else if (hitIn1)    rdSel = SEL_IN1;
    else if (hitInDis0) rdSel = SEL_INDIS0;
  end

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

  // R9
  read_only_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (busAddr == ADDR_W'(OFS_IN0) || busAddr == ADDR_W'(OFS_IN1)))
      |-> (stb == '0));

endmodule

// File: rtl/gpio_pair_dp.sv
module gpio_pair_dp
  import gpio_pair_pkg::*;
#(
  parameter int P0_W        = 8,
  parameter int P1_W        = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  gpioStrobe_t       stb,
  input  gpioRdSel_t        rdSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [P0_W-1:0]   p0PinIn,
  output logic [P0_W-1:0]   p0PinOut,
  output logic [P0_W-1:0]   p0OutEn,
  output logic [P0_W-1:0]   p0PullUp,
  input  logic [P1_W-1:0]   p1PinIn,
  output logic [P1_W-1:0]   p1PinOut,
  output logic [P1_W-1:0]   p1OutEn,
  output logic [P1_W-1:0]   p1PullUp
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [P0_W-1:0] out0Reg, dir0Reg, inDis0Reg;
  logic [P1_W-1:0] out1Reg, dir1Reg;
  logic [P0_W-1:0] sync0 [SYNC_STAGES];
  logic [P1_W-1:0] sync1 [SYNC_STAGES];
  logic [P0_W-1:0] in0Seen;
  logic [1:0]      upCnt;

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      out0Reg   <= '1;
      out1Reg   <= '1;
      dir0Reg   <= '0;
      dir1Reg   <= '0;
      inDis0Reg <= '0;
    end else begin
      if (stb.wrOut0)   out0Reg   <= wrData[P0_W-1:0];
      if (stb.wrOut1)   out1Reg   <= wrData[P1_W-1:0];
      if (stb.wrDir0)   dir0Reg   <= wrData[P0_W-1:0];
      if (stb.wrDir1)   dir1Reg   <= wrData[P1_W-1:0];
      if (stb.wrInDis0) inDis0Reg <= wrData[P0_W-1:0];
    end
  end

  // Input synchronizer chains
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) begin
        sync0[i] <= '0;
        sync1[i] <= '0;
      end
    end else begin
      sync0[0] <= p0PinIn;
      sync1[0] <= p1PinIn;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        sync0[i] <= sync0[i-1];
        sync1[i] <= sync1[i-1];
      end
    end
  end

  // Cycles since reset, saturating; used only by the checks below
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             upCnt <= '0;
    else if (upCnt != 2'd2) upCnt <= upCnt + 2'd1;
  end

  // Pad control: output bit doubles as pullup enable for inputs
  always_comb begin
    p0PinOut = out0Reg;
    p0OutEn  = dir0Reg;
    p0PullUp = out0Reg & ~dir0Reg;
    p1PinOut = out1Reg;
    p1OutEn  = dir1Reg;
    p1PullUp = out1Reg & ~dir1Reg;
  end

  assign in0Seen = sync0[LAST] & ~inDis0Reg;

  always_comb begin
    unique case (rdSel)
      SEL_OUT0:   rdData = DATA_W'(out0Reg);
      SEL_OUT1:   rdData = DATA_W'(out1Reg);
      SEL_DIR0:   rdData = DATA_W'(dir0Reg);
      SEL_DIR1:   rdData = DATA_W'(dir1Reg);
      SEL_IN0:    rdData = DATA_W'(in0Seen);
      SEL_IN1:    rdData = DATA_W'(sync1[LAST]);
      SEL_INDIS0: rdData = DATA_W'(inDis0Reg);
      default:    rdData = '0;
    endcase
  end

  // R2
  out0_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrOut0 |=> (out0Reg == $past(wrData[P0_W-1:0])));

  // R6
  dir_keeps_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrDir0 || stb.wrDir1) |=> ($stable(out0Reg) && $stable(out1Reg)));

  // R4
  no_pull_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((p0PullUp & p0OutEn) == '0) && ((p1PullUp & p1OutEn) == '0));

  // R8
  in_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel == SEL_IN0) |-> ((rdData[P0_W-1:0] & inDis0Reg) == '0));

  generate
    if (SYNC_STAGES == 2) begin : gSyncChk
      // R7
      sync_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
        (upCnt == 2'd2) |-> (sync0[LAST] == $past(p0PinIn, 2)));
    end
  endgenerate

endmodule

// File: rtl/gpio_pair_regs.sv
module gpio_pair_regs
  import gpio_pair_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int P0_W        = 8,
  parameter int P1_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [P0_W-1:0]   p0PinIn,
  output logic [P0_W-1:0]   p0PinOut,
  output logic [P0_W-1:0]   p0OutEn,
  output logic [P0_W-1:0]   p0PullUp,
  input  logic [P1_W-1:0]   p1PinIn,
  output logic [P1_W-1:0]   p1PinOut,
  output logic [P1_W-1:0]   p1OutEn,
  output logic [P1_W-1:0]   p1PullUp
);

  gpioStrobe_t stb;
  gpioRdSel_t  rdSel;

  gpio_pair_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .stb     (stb),
    .rdSel   (rdSel)
  );

  gpio_pair_dp #(
    .P0_W        (P0_W),
    .P1_W        (P1_W),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rdSel    (rdSel),
    .wrData   (busWrData),
    .rdData   (busRdData),
    .p0PinIn  (p0PinIn),
    .p0PinOut (p0PinOut),
    .p0OutEn  (p0OutEn),
    .p0PullUp (p0PullUp),
    .p1PinIn  (p1PinIn),
    .p1PinOut (p1PinOut),
    .p1OutEn  (p1OutEn),
    .p1PullUp (p1PullUp)
  );

endmodule

// File: tb/tb_gpio_pair_regs.sv
module tb_gpio_pair_regs;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic [7:0] p0PinIn = '0;
  logic [7:0] p0PinOut, p0OutEn, p0PullUp;
  logic [3:0] p1PinIn = '0;
  logic [3:0] p1PinOut, p1OutEn, p1PullUp;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  gpio_pair_regs dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .p0PinIn(p0PinIn), .p0PinOut(p0PinOut), .p0OutEn(p0OutEn), .p0PullUp(p0PullUp),
    .p1PinIn(p1PinIn), .p1PinOut(p1PinOut), .p1OutEn(p1OutEn), .p1PullUp(p1PullUp)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    busAddr = a;
    #1 v = busRdData;
  endtask

  task automatic testReset();
    logic [7:0] v;
    busRead(4'h0, v); check("R1 out0 reset", v, 8'hFF);
    busRead(4'h1, v); check("R1 out1 reset", v, 8'h0F);
    busRead(4'h2, v); check("R1 dir0 reset", v, 8'h00);
    busRead(4'h3, v); check("R1 dir1 reset", v, 8'h00);
    busRead(4'hA, v); check("R1 indis reset", v, 8'h00);
    check("R1 p0 oe reset", p0OutEn, 8'h00);
    check("R1 p0 pull reset", p0PullUp, 8'hFF);
    check("R1 p1 pull reset", {4'h0, p1PullUp}, 8'h0F);
  endtask

  task automatic testOut0();
    logic [7:0] v;
    busWrite(4'h0, 8'hA5); busRead(4'h0, v); check("R2 out0 A5", v, 8'hA5);
    busWrite(4'h0, 8'h3C); busRead(4'h0, v); check("R2 out0 3C", v, 8'h3C);
  endtask

  task automatic testOut1();
    logic [7:0] v;
    busWrite(4'h1, 8'hF6); busRead(4'h1, v); check("R3 out1 upper masked", v, 8'h06);
  endtask

  task automatic testPads();
    busWrite(4'h2, 8'hF0);
    busWrite(4'h0, 8'h5A);
    #1;
    check("R4 p0 oe", p0OutEn, 8'hF0);
    check("R4 p0 out", p0PinOut, 8'h5A);
    check("R5 p0 pull", p0PullUp, 8'h0A);
    busWrite(4'h3, 8'h03);
    busWrite(4'h1, 8'h09);
    #1;
    check("R4 p1 oe", {4'h0, p1OutEn}, 8'h03);
    check("R4 p1 out", {4'h0, p1PinOut}, 8'h09);
    check("R5 p1 pull", {4'h0, p1PullUp}, 8'h08);
  endtask

  task automatic testDirKeep();
    logic [7:0] v;
    busWrite(4'h2, 8'h0F); busRead(4'h0, v); check("R6 out0 kept", v, 8'h5A);
    busWrite(4'h3, 8'h0C); busRead(4'h1, v); check("R6 out1 kept", v, 8'h09);
  endtask

  task automatic testSync();
    logic [7:0] v;
    @(negedge clk);
    p0PinIn = 8'hC3; p1PinIn = 4'hA; busAddr = 4'h8;
    #1 check("R7 in0 before edges", busRdData, 8'h00);
    @(negedge clk); #1 check("R7 in0 after one edge", busRdData, 8'h00);
    @(negedge clk); #1 check("R7 in0 after two edges", busRdData, 8'hC3);
    busRead(4'h9, v); check("R7 in1 upper zero", v, 8'h0A);
  endtask

  task automatic testInDis();
    logic [7:0] v;
    busWrite(4'hA, 8'h0F); busRead(4'h8, v); check("R8 in0 gated", v, 8'hC0);
    busWrite(4'hA, 8'h00); busRead(4'h8, v); check("R8 in0 ungated", v, 8'hC3);
  endtask

  task automatic testIgnore();
    logic [7:0] v;
    busWrite(4'h8, 8'hFF); busRead(4'h8, v); check("R9 in0 write ignored", v, 8'hC3);
    busWrite(4'h9, 8'hFF); busRead(4'h9, v); check("R9 in1 write ignored", v, 8'h0A);
    busWrite(4'hE, 8'hAA); busRead(4'hE, v); check("R9 unmapped reads zero", v, 8'h00);
    busRead(4'h5, v); check("R9 unmapped 05 zero", v, 8'h00);
    busRead(4'h0, v); check("R9 out0 untouched", v, 8'h5A);
    busRead(4'h1, v); check("R9 out1 untouched", v, 8'h09);
    busRead(4'h2, v); check("R9 dir0 untouched", v, 8'h0F);
    busRead(4'hA, v); check("R9 indis untouched", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testOut0();
    testOut1();
    testPads();
    testDirKeep();
    testSync();
    testInDis();
    testIgnore();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule